// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block turns the control fields of a multi-source clock generator into one operating mode and drives the clock generator from that mode. The inputs are a two-bit output-source field, an internal-reference select, a PLL select, a low-power bit and a debug-enable flag. The block turns the FLL and PLL on or off, turns the reference oscillators on or off, picks the source of the local (debug) clock and steers the main output clock mux. The FLL, PLL and oscillators are analog parts and sit outside the block. They are represented here only by their enable lines and by a PLL lock input.

Three field combinations are legal:
- **Internal FLL-engaged.** This is the reset mode.
- **External FLL-bypassed.**
- **External PLL-engaged.** Entry into this mode waits for PLL lock, and the main clock stays on the external reference until then.

Any other combination keeps the current mode and raises a flag. The main clock mux changes source with a handshake that needs no glitch filtering. It first turns off the old source's gate while that source is low. It then turns on the new source's gate while the new source is low. Only after that does it update the reported clock status.

The block also reports two status items:
- The divided-reference frequency code is checked against the lock window of the active loop.
- The DCO-range status follows the range select, except in the PLL-engaged mode, where it reads zero.

Top module: `clkgen_mode_ctl`

## Requirements
- R1: After a synchronous active-low reset the state is as follows: mode code is 0 (internal FLL-engaged), `main_gate` is 3'b001, `clk_stat` is 0, `irc_en`=1, `fll_en`=1, `pll_en`=0, `osc_en`=0, `cfg_illegal`=0.
- R2: Internal FLL-engaged mode (code 0) is selected by `src_sel`=2'b00, `iref_sel`=1 and `pll_sel`=0, whatever the value of `low_pwr`. In this mode the main source and the local clock are both the FLL, `irc_en`=1 and `osc_en`=0.
- R3: External FLL-bypassed mode (code 1) is selected by `src_sel`=2'b10, `iref_sel`=0, `pll_sel`=0 and `low_pwr`=0. In this mode:
  - The main source is the external reference (source 1).
  - `fll_en`=1 and the local clock is the FLL (`lclk_sel`=0).
  - `pll_en`=0 and `osc_en`=1.
- R4: External PLL-engaged mode (code 2) is requested by `src_sel`=2'b00, `iref_sel`=0 and `pll_sel`=1. In this mode the main source is the PLL (source 2), and `pll_en`=1 and `osc_en`=1.
- R5: In mode 2 with `dbg_en`=1, the local clock is the open-loop DCO divided by two (`lclk_sel`=1) and `fll_en`=1. With `dbg_en`=0, `lclk_sel`=2 (off) and `fll_en`=0.
- R6: `dco_range` equals `drs_sel` in every mode except mode 2, where it reads 0.
- R7: `ref_err` is 1 when the reference code lies outside one of two inclusive windows, and 0 otherwise. The code's unit is 15.625 Hz.
  - In modes 0 and 1 the window is 2000..2500.
  - In modes 2 and 3 the window is 64000..128000.
- R8: A field combination matching none of R2–R4 leaves the mode unchanged and sets `cfg_illegal` one cycle later. `cfg_illegal` clears once a legal combination is applied.
- R9: A PLL-engaged request made while `pll_lock`=0 places the block in a wait mode (code 3). In that mode `pll_en`=1 and the main source stays the external reference. Mode 2 is entered only in a cycle after `pll_lock` has been seen high.
- R10: `main_gate` is one-hot or zero.
  - The old gate is cleared only at a clock edge where `src_low` of the old source is 1.
  - The new gate is set only at a clock edge where `src_low` of the new source is 1.
  - No gate goes directly from one source to another.
- R11: `clk_stat` (0=FLL, 1=external, 2=PLL) changes one cycle after the new gate is set. It always names the source whose gate is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Output-source field |
| iref_sel | input | 1 | Internal-reference select |
| pll_sel | input | 1 | PLL select |
| low_pwr | input | 1 | Low-power bit |
| dbg_en | input | 1 | Debug enable |
| drs_sel | input | 2 | DCO-range select |
| ref_code | input | 18 | Divided-reference frequency, 15.625 Hz units |
| pll_lock | input | 1 | PLL lock indication |
| src_low | input | 3 | Per-source "clock currently low" (0=FLL, 1=ext, 2=PLL) |
| mode | output | 2 | Mode code: 0 FLL-int, 1 FLL-bypass-ext, 2 PLL-ext, 3 PLL wait |
| main_gate | output | 3 | Main mux gate enables, one bit per source |
| clk_stat | output | 2 | Source reported after a completed switch |
| lclk_sel | output | 2 | Local clock: 0 FLL, 1 DCO/2, 2 off |
| fll_en | output | 1 | FLL enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | External oscillator enable |
| irc_en | output | 1 | Internal reference enable |
| dco_range | output | 2 | DCO-range status |
| ref_err | output | 1 | Reference outside lock window |
| cfg_illegal | output | 1 | Last applied fields match no mode |

## Verification
The bench applies all 64 combinations of source field, reference select, PLL select, low-power bit and debug enable in sequence. Because illegal combinations keep the mode, this order exercises both decode and hold behaviour against a tracked reference model. The reference code steps through values just inside and just outside both windows, which shows that the window follows the mode. The range select varies, which separates the forced-zero PLL-engaged status from normal pass-through. Directed sequences then hold PLL lock low and keep `src_low` low for chosen sources. These show that lock gating holds the external reference on the output and that each gate step waits on its own source's level.

// File: rtl/clkgen_mode_pkg.sv
// Shared codes for the clock generator mode controller.
// Assumes at most three main-clock sources and four modes.
package clkgen_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FEI   = 2'd0,
        MODE_FBE   = 2'd1,
        MODE_PEE   = 2'd2,
        MODE_PWAIT = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        SRC_FLL = 2'd0,
        SRC_EXT = 2'd1,
        SRC_PLL = 2'd2
    } src_t;

    typedef enum logic [1:0] {
        LCK_FLL  = 2'd0,
        LCK_DCO2 = 2'd1,
        LCK_OFF  = 2'd2
    } lclk_t;

    localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/clkgen_cfg_decode.sv
// Combinational decode of the control fields into a requested mode.
// Assumes fields are already stable register outputs; flags any
// combination that matches no defined mode.
module clkgen_cfg_decode
    import clkgen_mode_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       iref_sel,
    input  logic       pll_sel,
    input  logic       low_pwr,
    output logic       legal,
    output mode_t      req_mode
);

    // Match the field pattern of each defined mode.
    always_comb begin
        legal    = 1'b1;
        req_mode = MODE_FEI;
        if (src_sel == 2'b00 && iref_sel && !pll_sel) begin
            req_mode = MODE_FEI;
        end else if (src_sel == 2'b10 && !iref_sel && !pll_sel && !low_pwr) begin
            req_mode = MODE_FBE;
        end else if (src_sel == 2'b00 && !iref_sel && pll_sel) begin
            req_mode = MODE_PEE;
        end else begin
            legal = 1'b0;
        end
    end

endmodule

// File: rtl/clkgen_ref_check.sv
// Checks the divided-reference frequency code against the lock window
// of whichever loop the current mode uses. Windows are inclusive.
module clkgen_ref_check
    import clkgen_mode_pkg::*;
#(
    parameter int unsigned FREQ_W  = 18,
    parameter int unsigned FLL_MIN = 2000,
    parameter int unsigned FLL_MAX = 2500,
    parameter int unsigned PLL_MIN = 64000,
    parameter int unsigned PLL_MAX = 128000
) (
    input  mode_t             mode_q,
    input  logic [FREQ_W-1:0] ref_code,
    output logic              ref_err
);

    localparam logic [FREQ_W-1:0] FLO = FREQ_W'(FLL_MIN);
    localparam logic [FREQ_W-1:0] FHI = FREQ_W'(FLL_MAX);
    localparam logic [FREQ_W-1:0] PLO = FREQ_W'(PLL_MIN);
    localparam logic [FREQ_W-1:0] PHI = FREQ_W'(PLL_MAX);

    logic pll_side;

    // Pick the window by loop type and compare.
    always_comb begin
        pll_side = (mode_q == MODE_PEE) || (mode_q == MODE_PWAIT);
        if (pll_side) ref_err = (ref_code < PLO) || (ref_code > PHI);
        else          ref_err = (ref_code < FLO) || (ref_code > FHI);
    end

endmodule

// File: rtl/clkgen_clk_switch.sv
// Main-clock mux sequencer. When the requested source differs from the
// active one it clears the old gate while the old clock is low, then sets
// the new gate while the new clock is low, then reports the new source.
// Assumes src_low is already synchronised to clk.
module clkgen_clk_switch
    import clkgen_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  src_t               req_src,
    input  logic [NUM_SRC-1:0] src_low,
    output logic [NUM_SRC-1:0] gate,
    output src_t               stat
);

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_OFF  = 2'd1,
        SW_ON   = 2'd2,
        SW_DONE = 2'd3
    } sw_t;

    sw_t  st_q;
    src_t cur_q, tgt_q;

    // Switch state machine with gate and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SW_IDLE;
            cur_q <= SRC_FLL;
            tgt_q <= SRC_FLL;
            gate  <= 3'b001;
            stat  <= SRC_FLL;
        end else begin
            case (st_q)
                SW_IDLE: if (req_src != cur_q) begin
                    tgt_q <= req_src;
                    st_q  <= SW_OFF;
                end
                SW_OFF: if (src_low[cur_q]) begin
                    gate <= '0;
                    st_q <= SW_ON;
                end
                SW_ON: if (src_low[tgt_q]) begin
                    gate          <= '0;
                    gate[tgt_q]   <= 1'b1;
                    cur_q         <= tgt_q;
                    st_q          <= SW_DONE;
                end
                default: begin
                    stat <= cur_q;
                    st_q <= SW_IDLE;
                end
            endcase
        end
    end

    // R10: never more than one gate on.
    assert_gate_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate));

    // R10: an active gate only stays or turns off, never hops.
    assert_gate_no_hop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate != '0) |=> (gate == $past(gate) || gate == '0));

    // R10: a gate turns on only after its clock was seen low.
    assert_gate_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate == '0) |=> (gate == '0 || (|(gate & $past(src_low)))));

    // R11: reported status always matches the gate that is on.
    assert_stat_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat) |-> gate[stat]);

endmodule

// File: rtl/clkgen_mode_ctl.sv
// Clock generator mode controller top. Registers the operating mode from
// the decoded fields (holding on illegal input, waiting for PLL lock before
// PLL-engaged), drives loop/oscillator enables and local clock select,
// and runs the main mux switch sequencer.
// Assumes all inputs are synchronous to clk.
module clkgen_mode_ctl
    import clkgen_mode_pkg::*;
#(
    parameter int unsigned FREQ_W  = 18,
    parameter int unsigned DRS_W   = 2,
    parameter int unsigned FLL_MIN = 2000,
    parameter int unsigned FLL_MAX = 2500,
    parameter int unsigned PLL_MIN = 64000,
    parameter int unsigned PLL_MAX = 128000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic              iref_sel,
    input  logic              pll_sel,
    input  logic              low_pwr,
    input  logic              dbg_en,
    input  logic [DRS_W-1:0]  drs_sel,
    input  logic [FREQ_W-1:0] ref_code,
    input  logic              pll_lock,
    input  logic [2:0]        src_low,
    output logic [1:0]        mode,
    output logic [2:0]        main_gate,
    output logic [1:0]        clk_stat,
    output logic [1:0]        lclk_sel,
    output logic              fll_en,
    output logic              pll_en,
    output logic              osc_en,
    output logic              irc_en,
    output logic [DRS_W-1:0]  dco_range,
    output logic              ref_err,
    output logic              cfg_illegal
);

    logic  legal;
    mode_t req_mode, mode_q, mode_d;
    src_t  req_src, stat_s;
    lclk_t lclk_s;

    clkgen_cfg_decode u_dec (
        .src_sel  (src_sel),
        .iref_sel (iref_sel),
        .pll_sel  (pll_sel),
        .low_pwr  (low_pwr),
        .legal    (legal),
        .req_mode (req_mode)
    );

    // Next mode: hold on illegal fields, gate PLL-engaged on lock.
    always_comb begin
        if (!legal)                    mode_d = mode_q;
        else if (req_mode == MODE_PEE) mode_d = (mode_q == MODE_PEE || pll_lock) ? MODE_PEE : MODE_PWAIT;
        else                           mode_d = req_mode;
    end

    // Mode and illegal-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_FEI;
            cfg_illegal <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            cfg_illegal <= !legal;
        end
    end

    // Per-mode enables, sources and status.
    always_comb begin
        req_src   = SRC_FLL;
        lclk_s    = LCK_FLL;
        fll_en    = 1'b1;
        pll_en    = 1'b0;
        osc_en    = 1'b1;
        irc_en    = 1'b0;
        dco_range = drs_sel;
        case (mode_q)
            MODE_FEI: begin
                osc_en = 1'b0;
                irc_en = 1'b1;
            end
            MODE_FBE: req_src = SRC_EXT;
            MODE_PWAIT: begin
                req_src = SRC_EXT;
                pll_en  = 1'b1;
            end
            default: begin
                req_src   = SRC_PLL;
                pll_en    = 1'b1;
                dco_range = '0;
                fll_en    = dbg_en;
                lclk_s    = dbg_en ? LCK_DCO2 : LCK_OFF;
            end
        endcase
    end

    clkgen_ref_check #(
        .FREQ_W (FREQ_W), .FLL_MIN (FLL_MIN), .FLL_MAX (FLL_MAX),
        .PLL_MIN (PLL_MIN), .PLL_MAX (PLL_MAX)
    ) u_ref (
        .mode_q   (mode_q),
        .ref_code (ref_code),
        .ref_err  (ref_err)
    );

    clkgen_clk_switch u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_src (req_src),
        .src_low (src_low),
        .gate    (main_gate),
        .stat    (stat_s)
    );

    assign mode     = mode_q;
    assign clk_stat = stat_s;
    assign lclk_sel = lclk_s;

    // R8: illegal fields leave the mode untouched.
    assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!legal) |=> $stable(mode_q));

    // R9: PLL-engaged is entered only after lock was seen.
    assert_lock_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PEE && $past(mode_q) != MODE_PEE) |-> $past(pll_lock));

    // R6: range status follows the select outside PLL-engaged mode.
    assert_drs_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_PEE) |-> (dco_range == drs_sel));

    // R5: FLL off in PLL-engaged mode exactly when debug is off.
    assert_dbg_fll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PEE && !dbg_en) |-> (!fll_en && lclk_sel == 2'd2));

endmodule

// File: tb/sim_clkgen_mode_ctl.sv
module sim_clkgen_mode_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic        iref_sel = 1'b1, pll_sel = 1'b0, low_pwr = 1'b0, dbg_en = 1'b0;
    logic [1:0]  drs_sel = 2'd0;
    logic [17:0] ref_code = 18'd2200;
    logic        pll_lock = 1'b1;
    logic [2:0]  src_low = 3'b111;
    logic [1:0]  mode, clk_stat, lclk_sel, dco_range;
    logic [2:0]  main_gate;
    logic        fll_en, pll_en, osc_en, irc_en, ref_err, cfg_illegal;

    int total = 0;
    int bad = 0;
    int exp_mode = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkgen_mode_ctl u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .iref_sel(iref_sel),
        .pll_sel(pll_sel), .low_pwr(low_pwr), .dbg_en(dbg_en), .drs_sel(drs_sel),
        .ref_code(ref_code), .pll_lock(pll_lock), .src_low(src_low),
        .mode(mode), .main_gate(main_gate), .clk_stat(clk_stat), .lclk_sel(lclk_sel),
        .fll_en(fll_en), .pll_en(pll_en), .osc_en(osc_en), .irc_en(irc_en),
        .dco_range(dco_range), .ref_err(ref_err), .cfg_illegal(cfg_illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic int src_of(input int m);
        case (m)
            0: return 0;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check_mode_outputs(input string req, input int m);
        int s;
        int lo, hi;
        s = src_of(m);
        chk(req, "mode", mode, m);
        chk("R10", "gate", main_gate, 1 << s);
        chk("R11", "clk_stat", clk_stat, s);
        chk(req, "pll_en", pll_en, (m == 2 || m == 3) ? 1 : 0);
        chk(req, "osc_en", osc_en, (m != 0) ? 1 : 0);
        chk("R2", "irc_en", irc_en, (m == 0) ? 1 : 0);
        chk("R5", "fll_en", fll_en, (m == 2 && !dbg_en) ? 0 : 1);
        chk("R5", "lclk_sel", lclk_sel, (m == 2) ? (dbg_en ? 1 : 2) : 0);
        chk("R6", "dco_range", dco_range, (m == 2) ? 0 : int'(drs_sel));
        lo = (m >= 2) ? 64000 : 2000;
        hi = (m >= 2) ? 128000 : 2500;
        chk("R7", "ref_err", ref_err, (int'(ref_code) < lo || int'(ref_code) > hi) ? 1 : 0);
    endtask

    initial begin
        int refs[6] = '{1999, 2000, 2500, 2501, 64000, 128001};
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1", "mode", mode, 0);
        chk("R1", "gate", main_gate, 1);
        chk("R1", "clk_stat", clk_stat, 0);
        chk("R1", "irc_en", irc_en, 1);
        chk("R1", "pll_en", pll_en, 0);
        chk("R1", "osc_en", osc_en, 0);
        chk("R1", "cfg_illegal", cfg_illegal, 0);

        // Sweep all field combinations with lock held high.
        for (int i = 0; i < 64; i++) begin
            bit leg;
            int dm;
            src_sel  = i[1:0];
            iref_sel = i[2];
            pll_sel  = i[3];
            low_pwr  = i[4];
            dbg_en   = i[5];
            drs_sel  = 2'((i * 3 + 1) % 4);
            ref_code = 18'(refs[i % 6]);
            leg = 1'b1;
            if (src_sel == 2'b00 && iref_sel && !pll_sel) dm = 0;
            else if (src_sel == 2'b10 && !iref_sel && !pll_sel && !low_pwr) dm = 1;
            else if (src_sel == 2'b00 && !iref_sel && pll_sel) dm = 2;
            else begin dm = exp_mode; leg = 1'b0; end
            exp_mode = dm;
            cyc(14);
            check_mode_outputs(dm == 0 ? "R2" : (dm == 1 ? "R3" : "R4"), exp_mode);
            chk("R8", "cfg_illegal", cfg_illegal, leg ? 0 : 1);
        end

        // R9: PLL request without lock waits with external source.
        src_sel = 2'b00; iref_sel = 1'b1; pll_sel = 1'b0; low_pwr = 1'b0;
        dbg_en = 1'b1; ref_code = 18'd2200;
        cyc(14);
        chk("R2", "mode back to FEI", mode, 0);
        pll_lock = 1'b0;
        iref_sel = 1'b0; pll_sel = 1'b1; ref_code = 18'd70000;
        cyc(20);
        check_mode_outputs("R9", 3);
        pll_lock = 1'b1;
        cyc(14);
        check_mode_outputs("R9", 2);

        // R10/R11: step the switch by clock levels (PLL -> FLL).
        src_low = 3'b000;
        iref_sel = 1'b1; pll_sel = 1'b0; ref_code = 18'd2100;
        cyc(10);
        chk("R10", "old gate held while old high", main_gate, 3'b100);
        src_low = 3'b100;   // old low
        cyc(3);
        chk("R10", "gates off", main_gate, 3'b000);
        chk("R11", "stat unchanged", clk_stat, 2);
        src_low = 3'b000;
        cyc(5);
        chk("R10", "new waits for low", main_gate, 3'b000);
        src_low = 3'b001;   // new low
        cyc(1);
        chk("R10", "new gate on", main_gate, 3'b001);
        chk("R11", "stat before done", clk_stat, 2);
        cyc(1);
        chk("R11", "stat after done", clk_stat, 0);
        src_low = 3'b111;
        done = 1'b1;
    end

    initial begin
        for (int w = 0; w < 50000; w++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule